// File: doc/BRIEF.md
# Operand Bypass Selector and Load Interlock

This block is the data-hazard controller of a five-stage, single-issue, in-order integer pipeline. It looks at the two source register numbers of the instruction about to execute. It compares each of them with the destination numbers carried by the two younger result-holding pipeline registers. These are the execute/memory register, which holds the most recent result, and the memory/writeback register, which holds the result one instruction older. From that comparison it produces the select code for each ALU operand multiplexer. Each multiplexer can take the register-file value or one of the two in-flight results.

The same controller also guards against the one case that bypassing cannot cover. That case is a load sitting in the decode/execute register while the instruction behind it, still in the fetch/decode register, reads the register the load will write. When that happens, the block drops the program-counter and fetch/decode enables for one cycle and orders the decode/execute register to take a bubble. Once the load has moved on, the waiting instruction reads the value through the writeback-stage bypass.

The controller is purely combinational: every output follows the present inputs, so it sits between the pipeline registers it steers without adding a cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: With no producer matching any source, both operand selects are 2'b00 (register file), `pc_en` and `ifid_en` are 1 and `idex_flush` is 0.
- R2: A source in the execute stage equal to `exmem_rd`, with `exmem_we` = 1 and `exmem_rd` nonzero, gets select 2'b10.
- R3: A source equal to `memwb_rd`, with `memwb_we` = 1 and `memwb_rd` nonzero, and no R2 match, gets select 2'b01.
- R4: When both producers match the same source, the execute/memory result wins (select 2'b10).
- R5: A destination of register 0 never causes a bypass or a stall, even when the sources are also 0.
- R6: A producer whose write enable is 0 never causes a bypass, and a load whose write enable is 0 never causes a stall.
- R7: When `idex_mem_rd` = 1, `idex_we` = 1, `idex_rd` is nonzero and equals a used decode-stage source, the outputs are `pc_en` = 0, `ifid_en` = 0 and `idex_flush` = 1. Otherwise they are 1, 1, 0.
- R8: A decode-stage source whose use flag is 0 never causes a stall, whatever its value.
- R9: The two operand selects are decided independently: operand A (`idex_rs1`) and operand B (`idex_rs2`) may take different sources in the same cycle.
- R10: Only a load in the decode/execute register stalls. After the bubble, the same load in the execute/memory register causes no stall. One cycle later the waiting instruction gets select 2'b01 for that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs1 | input | AW | First source register of the instruction in decode |
| ifid_rs2 | input | AW | Second source register of the instruction in decode |
| ifid_rs1_use | input | 1 | The decode instruction reads its first source |
| ifid_rs2_use | input | 1 | The decode instruction reads its second source |
| idex_rs1 | input | AW | First source register of the instruction in execute |
| idex_rs2 | input | AW | Second source register of the instruction in execute |
| idex_rd | input | AW | Destination of the instruction in execute |
| idex_we | input | 1 | The instruction in execute writes a register |
| idex_mem_rd | input | 1 | The instruction in execute is a load |
| exmem_rd | input | AW | Destination held in the execute/memory register |
| exmem_we | input | 1 | Write enable held in the execute/memory register |
| memwb_rd | input | AW | Destination held in the memory/writeback register |
| memwb_we | input | 1 | Write enable held in the memory/writeback register |
| fwd_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b | output | 2 | Operand B source, same code as `fwd_a` |
| pc_en | output | 1 | Program counter may update |
| ifid_en | output | 1 | Fetch/decode register may update |
| idex_flush | output | 1 | Load a bubble into the decode/execute register |

## Verification
The bench drives single-producer matches on each operand, double matches on the same operand, and split matches where A and B draw from different stages. These patterns separate a wrong priority from a wrong operand wiring. Register-0 destinations and cleared write enables are driven while the register numbers still agree, so a comparator that ignores either qualifier shows up. Load-use cases vary which source collides and whether that source is used. A three-cycle load, bubble and consumer sequence confirms that the stall lasts one cycle and that the consumer is then served from the writeback bypass. A long run of random vectors over a narrow register range makes collisions frequent and is compared every cycle against the bench's own model.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
    // Operand source code; the bit positions are decoded by the ALU input muxes.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;
endpackage

// File: rtl/hz_operand_sel.sv
`timescale 1ns/1ps
module hz_operand_sel
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output opnd_src_e     sel
);
    logic mem_hit_d;
    logic wb_hit_d;

    always_comb begin
        mem_hit_d = mem_we && (mem_rd != '0) && (mem_rd == src);
        wb_hit_d  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        // Younger result first: it supersedes the older one for the same register.
        if (mem_hit_d) begin
            sel = SRC_MEM;
        end else if (wb_hit_d) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_REGFILE;
        end
    end
endmodule

// File: rtl/hz_loaduse_detect.sv
`timescale 1ns/1ps
module hz_loaduse_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] src,
    input  logic [NSRC-1:0]         src_use,
    input  logic [AW-1:0]           ld_rd,
    input  logic                    ld_we,
    input  logic                    ld_mem_rd,
    output logic                    hazard
);
    logic [NSRC-1:0] hit_d;
    logic            ld_live_d;

    assign ld_live_d = ld_mem_rd && ld_we && (ld_rd != '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit_d[i] = src_use[i] && (src[i] == ld_rd);
    end

    assign hazard = ld_live_d && (|hit_d);
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] ifid_rs1,
    input  logic [AW-1:0] ifid_rs2,
    input  logic          ifid_rs1_use,
    input  logic          ifid_rs2_use,
    input  logic [AW-1:0] idex_rs1,
    input  logic [AW-1:0] idex_rs2,
    input  logic [AW-1:0] idex_rd,
    input  logic          idex_we,
    input  logic          idex_mem_rd,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_we,
    input  logic [AW-1:0] memwb_rd,
    input  logic          memwb_we,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_en,
    output logic          ifid_en,
    output logic          idex_flush
);
    localparam int NOPS = 2;

    typedef struct packed {
        logic                  pc_en;
        logic                  ifid_en;
        logic                  idex_flush;
        logic [NOPS-1:0][1:0]  fwd;
    } ctrl_t;

    logic [NOPS-1:0][AW-1:0] ex_src_d;
    logic [NOPS-1:0][AW-1:0] id_src_d;
    logic [NOPS-1:0]         id_use_d;
    opnd_src_e               sel_d [NOPS];
    logic                    stall_d;
    ctrl_t                   ctrl_d;

    assign ex_src_d = {idex_rs2, idex_rs1};
    assign id_src_d = {ifid_rs2, ifid_rs1};
    assign id_use_d = {ifid_rs2_use, ifid_rs1_use};

    for (genvar k = 0; k < NOPS; k++) begin : g_opnd
        hz_operand_sel #(.AW(AW)) u_sel (
            .src    (ex_src_d[k]),
            .mem_rd (exmem_rd),
            .mem_we (exmem_we),
            .wb_rd  (memwb_rd),
            .wb_we  (memwb_we),
            .sel    (sel_d[k])
        );
    end

    hz_loaduse_detect #(.AW(AW), .NSRC(NOPS)) u_ld (
        .src       (id_src_d),
        .src_use   (id_use_d),
        .ld_rd     (idex_rd),
        .ld_we     (idex_we),
        .ld_mem_rd (idex_mem_rd),
        .hazard    (stall_d)
    );

    always_comb begin
        ctrl_d            = '0;
        ctrl_d.pc_en      = !stall_d;
        ctrl_d.ifid_en    = !stall_d;
        ctrl_d.idex_flush = stall_d;
        for (int k = 0; k < NOPS; k++) begin
            ctrl_d.fwd[k] = sel_d[k];
        end
    end

    assign fwd_a      = ctrl_d.fwd[0];
    assign fwd_b      = ctrl_d.fwd[1];
    assign pc_en      = ctrl_d.pc_en;
    assign ifid_en    = ctrl_d.ifid_en;
    assign idex_flush = ctrl_d.idex_flush;
endmodule

// File: rtl/hazard_ctrl_chk.sv
`timescale 1ns/1ps
module hazard_ctrl_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] ifid_rs1,
    input logic [AW-1:0] ifid_rs2,
    input logic          ifid_rs1_use,
    input logic          ifid_rs2_use,
    input logic [AW-1:0] idex_rs1,
    input logic [AW-1:0] idex_rs2,
    input logic [AW-1:0] idex_rd,
    input logic          idex_we,
    input logic          idex_mem_rd,
    input logic [AW-1:0] exmem_rd,
    input logic          exmem_we,
    input logic [AW-1:0] memwb_rd,
    input logic          memwb_we,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          pc_en,
    input logic          ifid_en,
    input logic          idex_flush
);
    logic mem_a, mem_b, wb_a, wb_b, ld_cause;

    always_comb begin
        mem_a = exmem_we && (exmem_rd != '0) && (exmem_rd == idex_rs1);
        mem_b = exmem_we && (exmem_rd != '0) && (exmem_rd == idex_rs2);
        wb_a  = memwb_we && (memwb_rd != '0) && (memwb_rd == idex_rs1);
        wb_b  = memwb_we && (memwb_rd != '0) && (memwb_rd == idex_rs2);
        ld_cause = idex_mem_rd && idex_we && (idex_rd != '0) &&
                   ((ifid_rs1_use && ifid_rs1 == idex_rd) ||
                    (ifid_rs2_use && ifid_rs2 == idex_rd));

        p_legal_code_r2: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
            else $error("R2: illegal operand select");
        p_mem_origin_a_r2: assert (fwd_a != 2'b10 || mem_a)
            else $error("R2: operand A bypass from execute/memory without a match");
        p_mem_origin_b_r9: assert (fwd_b != 2'b10 || mem_b)
            else $error("R9: operand B bypass from execute/memory without a match");
        p_wb_origin_r3: assert (fwd_a != 2'b01 || (wb_a && !mem_a))
            else $error("R3: operand A writeback bypass not justified");
        p_priority_r4: assert (!(mem_b && wb_b) || fwd_b == 2'b10)
            else $error("R4: older result chosen over younger");
        p_flush_origin_r7: assert (!idex_flush || ld_cause)
            else $error("R7: bubble without a load-use collision");
        p_unused_quiet_r8: assert ((ifid_rs1_use || ifid_rs2_use) ||
                                   (pc_en && ifid_en && !idex_flush))
            else $error("R8: stall with no source in use");
    end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_tb;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] ifid_rs1, ifid_rs2, idex_rs1, idex_rs2, idex_rd, exmem_rd, memwb_rd;
    logic ifid_rs1_use, ifid_rs2_use, idex_we, idex_mem_rd, exmem_we, memwb_we;
    logic [1:0] fwd_a, fwd_b;
    logic pc_en, ifid_en, idex_flush;

    int checks = 0;
    int errors = 0;

    hazard_ctrl #(.AW(AW)) u_dut (.*);

    // Behavioural model of the selection rules.
    function automatic logic [1:0] want_sel(logic [AW-1:0] s);
        if (exmem_we && exmem_rd != 0 && exmem_rd == s) return 2'b10;
        if (memwb_we && memwb_rd != 0 && memwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic want_stall();
        logic live = idex_mem_rd && idex_we && (idex_rd != 0);
        return live && ((ifid_rs1_use && ifid_rs1 == idex_rd) ||
                        (ifid_rs2_use && ifid_rs2 == idex_rd));
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check(string req);
        logic st = want_stall();
        cmp(req, "fwd_a", fwd_a, want_sel(idex_rs1));
        cmp(req, "fwd_b", fwd_b, want_sel(idex_rs2));
        cmp(req, "pc_en", pc_en, !st);
        cmp(req, "ifid_en", ifid_en, !st);
        cmp(req, "idex_flush", idex_flush, st);
    endtask

    task automatic clr();
        {ifid_rs1, ifid_rs2, idex_rs1, idex_rs2, idex_rd, exmem_rd, memwb_rd} = '0;
        {ifid_rs1_use, ifid_rs2_use, idex_we, idex_mem_rd, exmem_we, memwb_we} = '0;
    endtask

    // Inputs are set just after a rising edge; outputs are read at the falling edge.
    task automatic tick(string req);
        @(negedge clk);
        check(req);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog all actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr();
        @(posedge clk); #1;
        tick("R1");                                                   // idle
        idex_rs1 = 5; idex_rs2 = 3; exmem_rd = 5; exmem_we = 1; tick("R2");
        if (fwd_a !== 2'b10) cmp("R2", "fwd_a direct", fwd_a, 2);
        clr(); idex_rs2 = 6; memwb_rd = 6; memwb_we = 1; tick("R3");
        clr(); idex_rs1 = 7; exmem_rd = 7; exmem_we = 1; memwb_rd = 7; memwb_we = 1; tick("R4");
        cmp("R4", "fwd_a priority", fwd_a, 2);
        clr(); exmem_we = 1; memwb_we = 1; tick("R5");                // all zero registers
        cmp("R5", "fwd_a x0", fwd_a, 0);
        clr(); idex_mem_rd = 1; idex_we = 1; ifid_rs1_use = 1; ifid_rs2_use = 1; tick("R5");
        cmp("R5", "pc_en x0 load", pc_en, 1);
        clr(); idex_rs1 = 4; idex_rs2 = 9; exmem_rd = 4; memwb_rd = 9; tick("R6");
        cmp("R6", "fwd_b no we", fwd_b, 0);
        clr(); idex_mem_rd = 1; idex_rd = 8; ifid_rs1 = 8; ifid_rs1_use = 1; tick("R6");
        cmp("R6", "flush no we", idex_flush, 0);
        clr(); idex_mem_rd = 1; idex_we = 1; idex_rd = 12; ifid_rs2 = 12; ifid_rs2_use = 1; tick("R7");
        cmp("R7", "flush", idex_flush, 1);
        cmp("R7", "pc_en", pc_en, 0);
        clr(); idex_we = 1; idex_rd = 12; ifid_rs1 = 12; ifid_rs1_use = 1; tick("R7");  // ALU producer
        cmp("R7", "no stall non-load", pc_en, 1);
        clr(); idex_mem_rd = 1; idex_we = 1; idex_rd = 14; ifid_rs1 = 14; ifid_rs2 = 14; tick("R8");
        cmp("R8", "flush unused", idex_flush, 0);
        clr(); idex_rs1 = 2; idex_rs2 = 3; exmem_rd = 2; exmem_we = 1; memwb_rd = 3; memwb_we = 1; tick("R9");
        cmp("R9", "fwd_a split", fwd_a, 2);
        cmp("R9", "fwd_b split", fwd_b, 1);
        // Load, bubble, consumer.
        clr(); idex_mem_rd = 1; idex_we = 1; idex_rd = 9; ifid_rs1 = 9; ifid_rs1_use = 1; tick("R10");
        cmp("R10", "first cycle stall", pc_en, 0);
        clr(); exmem_rd = 9; exmem_we = 1; ifid_rs1 = 9; ifid_rs1_use = 1; tick("R10");
        cmp("R10", "bubble cycle no stall", idex_flush, 0);
        clr(); idex_rs1 = 9; memwb_rd = 9; memwb_we = 1; tick("R10");
        cmp("R10", "consumer from writeback", fwd_a, 1);
        // Random vectors over a narrow register range.
        for (int n = 0; n < 400; n++) begin
            string tag;
            ifid_rs1 = $urandom_range(0, 3); ifid_rs2 = $urandom_range(0, 3);
            idex_rs1 = $urandom_range(0, 3); idex_rs2 = $urandom_range(0, 3);
            idex_rd  = $urandom_range(0, 3); exmem_rd = $urandom_range(0, 3);
            memwb_rd = $urandom_range(0, 3);
            ifid_rs1_use = 1'($urandom_range(0, 1)); ifid_rs2_use = 1'($urandom_range(0, 1));
            idex_we  = 1'($urandom_range(0, 1)); idex_mem_rd = 1'($urandom_range(0, 1));
            exmem_we = 1'($urandom_range(0, 1)); memwb_we = 1'($urandom_range(0, 1));
            if (want_stall()) tag = "R7";
            else if (want_sel(idex_rs1) == 2'b10 || want_sel(idex_rs2) == 2'b10) tag = "R2";
            else if (want_sel(idex_rs1) == 2'b01 || want_sel(idex_rs2) == 2'b01) tag = "R3";
            else tag = "R1";
            tick(tag);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule